// File: doc/BRIEF.md
# Two-Word Packed Key Merger

This block takes two W-bit words, each packed with K unsigned keys of W/K bits. One word is sorted upward along the field index and the other is sorted downward, so the pair read end to end forms a single bitonic run of 2K keys. After a fixed pipeline delay it returns two words. One holds the K largest keys of the pair and the other holds the K smallest. The caller picks the sort sense of each output word on its own, which lets a sequential merge loop feed one result straight back as the next operand without a reversal step.

The datapath has two parts. A first stage compares the two input words field by field and routes the larger key of each pair to the high word and the smaller key to the low word. Each of these words is bitonic. Each word then passes through its own chain of log2(K) in-word bitonic stages. The pipeline accepts a new pair on every cycle.

Top module: `packed_merge2`

## Requirements
- R1: A pair sampled with `in_valid` high at a rising edge produces exactly one `out_valid` pulse, LAT = log2(KEYS)+1 edges later, with results in the order of acceptance.
- R2: No `out_valid` is produced for cycles in which `in_valid` is low, whatever the other inputs carry.
- R3: `hi_word` holds the KEYS largest keys of the 2·KEYS inputs, so every key in `hi_word` is greater than or equal to every key in `lo_word`.
- R4: The 2·KEYS output keys form exactly the same multiset as the input keys, duplicates included.
- R5: Field f of a word occupies bits [f·FIELD_W +: FIELD_W]. A direction bit of 1 makes that output word nondecreasing as f rises. A bit of 0 makes it nonincreasing. `hi_up` governs `hi_word` and `lo_up` governs `lo_word`, independently.
- R6: The direction bits are sampled on the same edge as the input words. Their values in later cycles do not affect a pair already accepted.
- R7: Keys are unsigned and may use every bit of the field. This includes all-ones fields and zero fields on either side of a comparison.
- R8: During synchronous reset, `out_valid` is low and both output words are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair is present this cycle |
| up_word | input | WORD_W | Keys nondecreasing with field index |
| down_word | input | WORD_W | Keys nonincreasing with field index |
| hi_up | input | 1 | Sort sense for the high result (1 = nondecreasing) |
| lo_up | input | 1 | Sort sense for the low result (1 = nondecreasing) |
| out_valid | output | 1 | Result words are present this cycle |
| hi_word | output | WORD_W | The KEYS largest keys |
| lo_word | output | WORD_W | The KEYS smallest keys |

## Verification
The ordering and separation properties rely on one input rule: whenever `in_valid` is high, `up_word` is sorted upward and `down_word` is sorted downward. If that rule is broken, the first stage no longer yields bitonic halves. The bench builds every valid operand by sorting random keys in the required sense, and it restricts some runs to narrow value sets to force duplicates. In idle cycles it deliberately drives unsorted data and flips the direction bits, which is allowed because nothing is accepted then.

// File: rtl/pmerge_pkg.sv
package pmerge_pkg;

    // Default geometry: eight byte-wide keys in a 64-bit word.
    localparam int unsigned DEF_WORD_W = 64;
    localparam int unsigned DEF_KEYS   = 8;

    // Sort sense of one output word along rising field index.
    typedef enum logic {
        ORD_DOWN = 1'b0,
        ORD_UP   = 1'b1
    } key_order_e;

    // Direction pair captured together with an operand pair.
    typedef struct packed {
        key_order_e hi_ord;
        key_order_e lo_ord;
    } order_ctl_t;

    // Number of in-word bitonic stages for a given key count.
    function automatic int unsigned merge_depth(input int unsigned keys);
        return $clog2(keys);
    endfunction

    // Total register stages from input sample to result.
    function automatic int unsigned pipe_latency(input int unsigned keys);
        return merge_depth(keys) + 1;
    endfunction

endpackage

// File: rtl/pm_half_clean.sv
module pm_half_clean
    import pmerge_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned KEYS   = DEF_KEYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] up_word,
    input  logic [WORD_W-1:0] down_word,
    input  order_ctl_t        ctl_in,
    output logic [WORD_W-1:0] big_q,
    output logic [WORD_W-1:0] small_q,
    output order_ctl_t        ctl_q
);
    localparam int unsigned FIELD_W = WORD_W / KEYS;

    // Per-field mask: all ones where the upward key is >= its partner.
    logic [WORD_W-1:0] ge_mask;
    logic [WORD_W-1:0] big_d;
    logic [WORD_W-1:0] small_d;

    for (genvar f = 0; f < KEYS; f++) begin : g_field
        assign ge_mask[f*FIELD_W +: FIELD_W] =
            {FIELD_W{up_word[f*FIELD_W +: FIELD_W] >= down_word[f*FIELD_W +: FIELD_W]}};
    end

    assign big_d   = (up_word & ge_mask)   | (down_word & ~ge_mask);
    assign small_d = (down_word & ge_mask) | (up_word & ~ge_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            big_q   <= '0;
            small_q <= '0;
            ctl_q   <= '{hi_ord: ORD_DOWN, lo_ord: ORD_DOWN};
        end else begin
            big_q   <= big_d;
            small_q <= small_d;
            ctl_q   <= ctl_in;
        end
    end

endmodule

// File: rtl/pm_bitonic_stage.sv
module pm_bitonic_stage
    import pmerge_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned KEYS   = DEF_KEYS,
    parameter int unsigned SPAN   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] d_in,
    input  key_order_e        ord_in,
    output logic [WORD_W-1:0] d_q,
    output key_order_e        ord_q
);
    localparam int unsigned FIELD_W = WORD_W / KEYS;

    logic [WORD_W-1:0] d_nxt;

    // Each lane in the lower half of a 2*SPAN block owns one compare-exchange.
    for (genvar i = 0; i < KEYS; i++) begin : g_lane
        if (((i / SPAN) % 2) == 0) begin : g_pair
            localparam int unsigned J = i + SPAN;
            logic [FIELD_W-1:0] key_a;
            logic [FIELD_W-1:0] key_b;
            logic [FIELD_W-1:0] key_min;
            logic [FIELD_W-1:0] key_max;
            logic               a_le_b;

            assign key_a   = d_in[i*FIELD_W +: FIELD_W];
            assign key_b   = d_in[J*FIELD_W +: FIELD_W];
            assign a_le_b  = key_a <= key_b;
            assign key_min = a_le_b ? key_a : key_b;
            assign key_max = a_le_b ? key_b : key_a;

            assign d_nxt[i*FIELD_W +: FIELD_W] = (ord_in == ORD_UP) ? key_min : key_max;
            assign d_nxt[J*FIELD_W +: FIELD_W] = (ord_in == ORD_UP) ? key_max : key_min;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q   <= '0;
            ord_q <= ORD_DOWN;
        end else begin
            d_q   <= d_nxt;
            ord_q <= ord_in;
        end
    end

endmodule

// File: rtl/pm_word_sort.sv
module pm_word_sort
    import pmerge_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned KEYS   = DEF_KEYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] d_in,
    input  key_order_e        ord_in,
    output logic [WORD_W-1:0] d_out
);
    localparam int unsigned STAGES = merge_depth(KEYS);

    logic [WORD_W-1:0] chain_d [STAGES+1];
    key_order_e        chain_o [STAGES+1];

    assign chain_d[0] = d_in;
    assign chain_o[0] = ord_in;

    // Spans halve from KEYS/2 down to 1.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        pm_bitonic_stage #(
            .WORD_W (WORD_W),
            .KEYS   (KEYS),
            .SPAN   (KEYS >> (s + 1))
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .d_in   (chain_d[s]),
            .ord_in (chain_o[s]),
            .d_q    (chain_d[s+1]),
            .ord_q  (chain_o[s+1])
        );
    end

    assign d_out = chain_d[STAGES];

endmodule

// File: rtl/packed_merge2.sv
module packed_merge2
    import pmerge_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned KEYS   = DEF_KEYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] up_word,
    input  logic [WORD_W-1:0] down_word,
    input  logic              hi_up,
    input  logic              lo_up,
    output logic              out_valid,
    output logic [WORD_W-1:0] hi_word,
    output logic [WORD_W-1:0] lo_word
);
    localparam int unsigned LAT = pipe_latency(KEYS);

    order_ctl_t        ctl_in;
    order_ctl_t        ctl_s0;
    logic [WORD_W-1:0] big_s0;
    logic [WORD_W-1:0] small_s0;
    logic [LAT-1:0]    vld_sr;

    assign ctl_in.hi_ord = key_order_e'(hi_up);
    assign ctl_in.lo_ord = key_order_e'(lo_up);

    pm_half_clean #(
        .WORD_W (WORD_W),
        .KEYS   (KEYS)
    ) u_split (
        .clk       (clk),
        .rst       (rst),
        .up_word   (up_word),
        .down_word (down_word),
        .ctl_in    (ctl_in),
        .big_q     (big_s0),
        .small_q   (small_s0),
        .ctl_q     (ctl_s0)
    );

    pm_word_sort #(
        .WORD_W (WORD_W),
        .KEYS   (KEYS)
    ) u_hi_sort (
        .clk    (clk),
        .rst    (rst),
        .d_in   (big_s0),
        .ord_in (ctl_s0.hi_ord),
        .d_out  (hi_word)
    );

    pm_word_sort #(
        .WORD_W (WORD_W),
        .KEYS   (KEYS)
    ) u_lo_sort (
        .clk    (clk),
        .rst    (rst),
        .d_in   (small_s0),
        .ord_in (ctl_s0.lo_ord),
        .d_out  (lo_word)
    );

    // Valid travels alongside the data through all LAT register stages.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= (vld_sr << 1) | LAT'(in_valid);
        end
    end

    assign out_valid = vld_sr[LAT-1];

endmodule

// File: rtl/pm_merge_chk.sv
module pm_merge_chk
    import pmerge_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned KEYS   = DEF_KEYS
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] up_word,
    input logic [WORD_W-1:0] down_word,
    input logic              hi_up,
    input logic              lo_up,
    input logic              out_valid,
    input logic [WORD_W-1:0] hi_word,
    input logic [WORD_W-1:0] lo_word
);
    localparam int unsigned FIELD_W = WORD_W / KEYS;
    localparam int unsigned LAT     = pipe_latency(KEYS);
    localparam int unsigned SUM_W   = FIELD_W + $clog2(2 * KEYS) + 1;

    function automatic logic [SUM_W-1:0] key_sum(input logic [WORD_W-1:0] w);
        logic [SUM_W-1:0] s;
        s = '0;
        for (int i = 0; i < KEYS; i++) s += SUM_W'(w[i*FIELD_W +: FIELD_W]);
        return s;
    endfunction

    function automatic logic is_ordered(input logic [WORD_W-1:0] w, input logic up);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i + 1 < KEYS; i++) begin
            if (up  && (w[i*FIELD_W +: FIELD_W] > w[(i+1)*FIELD_W +: FIELD_W])) ok = 1'b0;
            if (!up && (w[i*FIELD_W +: FIELD_W] < w[(i+1)*FIELD_W +: FIELD_W])) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [FIELD_W-1:0] min_key(input logic [WORD_W-1:0] w);
        logic [FIELD_W-1:0] m;
        m = '1;
        for (int i = 0; i < KEYS; i++)
            if (w[i*FIELD_W +: FIELD_W] < m) m = w[i*FIELD_W +: FIELD_W];
        return m;
    endfunction

    function automatic logic [FIELD_W-1:0] max_key(input logic [WORD_W-1:0] w);
        logic [FIELD_W-1:0] m;
        m = '0;
        for (int i = 0; i < KEYS; i++)
            if (w[i*FIELD_W +: FIELD_W] > m) m = w[i*FIELD_W +: FIELD_W];
        return m;
    endfunction

    // Independent delay lines of the accepted inputs.
    logic [LAT-1:0]   v_dly;
    logic [LAT-1:0]   hu_dly;
    logic [LAT-1:0]   lu_dly;
    logic [SUM_W-1:0] sum_dly [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_dly  <= '0;
            hu_dly <= '0;
            lu_dly <= '0;
            for (int i = 0; i < LAT; i++) sum_dly[i] <= '0;
        end else begin
            v_dly      <= (v_dly  << 1) | LAT'(in_valid);
            hu_dly     <= (hu_dly << 1) | LAT'(hi_up);
            lu_dly     <= (lu_dly << 1) | LAT'(lo_up);
            sum_dly[0] <= key_sum(up_word) + key_sum(down_word);
            for (int i = 1; i < LAT; i++) sum_dly[i] <= sum_dly[i-1];
        end
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_dly[LAT-1]);

    // R5
    hi_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> is_ordered(hi_word, hu_dly[LAT-1]));

    // R5
    lo_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> is_ordered(lo_word, lu_dly[LAT-1]));

    // R3
    split_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (min_key(hi_word) >= max_key(lo_word)));

    // R4
    key_sum_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((key_sum(hi_word) + key_sum(lo_word)) == sum_dly[LAT-1]));

endmodule

bind packed_merge2 pm_merge_chk #(
    .WORD_W (WORD_W),
    .KEYS   (KEYS)
) u_merge_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .up_word   (up_word),
    .down_word (down_word),
    .hi_up     (hi_up),
    .lo_up     (lo_up),
    .out_valid (out_valid),
    .hi_word   (hi_word),
    .lo_word   (lo_word)
);

// File: tb/packed_merge2_tb_top.sv
module packed_merge2_tb_top;

    localparam int unsigned W   = 64;
    localparam int unsigned K   = 8;
    localparam int unsigned F   = W / K;
    localparam int unsigned LAT = $clog2(K) + 1;
    localparam int unsigned FMAX = (1 << F) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] up_word = '0;
    logic [W-1:0] down_word = '0;
    logic         hi_up = 1'b0;
    logic         lo_up = 1'b0;
    logic         out_valid;
    logic [W-1:0] hi_word;
    logic [W-1:0] lo_word;

    packed_merge2 #(.WORD_W(W), .KEYS(K)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .up_word   (up_word),
        .down_word (down_word),
        .hi_up     (hi_up),
        .lo_up     (lo_up),
        .out_valid (out_valid),
        .hi_word   (hi_word),
        .lo_word   (lo_word)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        int           cyc;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    bit   done     = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (!done && cyc > 100000) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected<100000", cyc);
            finish_run();
        end
    end

    task automatic sort_keys(inout int unsigned a [K], input bit descending);
        for (int i = 0; i < K; i++)
            for (int j = 0; j + 1 < K - i; j++)
                if ((descending && a[j] < a[j+1]) || (!descending && a[j] > a[j+1])) begin
                    int unsigned t;
                    t = a[j]; a[j] = a[j+1]; a[j+1] = t;
                end
    endtask

    // Drive one pair; called at a rising edge plus 1 time unit.
    task automatic issue(input int unsigned ua [K], input int unsigned da [K],
                         input bit hu, input bit lu, input string tag);
        int unsigned all [2*K];
        exp_t e;
        for (int i = 0; i < K; i++) begin
            all[i]     = ua[i];
            all[K + i] = da[i];
        end
        for (int i = 0; i < 2*K; i++)
            for (int j = 0; j + 1 < 2*K - i; j++)
                if (all[j] < all[j+1]) begin
                    int unsigned t;
                    t = all[j]; all[j] = all[j+1]; all[j+1] = t;
                end
        for (int i = 0; i < K; i++) begin
            e.hi[i*F +: F] = F'(hu ? all[K-1-i]   : all[i]);
            e.lo[i*F +: F] = F'(lu ? all[2*K-1-i] : all[K+i]);
            up_word[i*F +: F]   = F'(ua[i]);
            down_word[i*F +: F] = F'(da[i]);
        end
        e.cyc = cyc + LAT;
        e.tag = tag;
        exp_q.push_back(e);
        hi_up    = hu;
        lo_up    = lu;
        in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid  = 1'b0;
        // R6/R2: scramble everything once the pair is taken
        hi_up     = ~hu;
        lo_up     = ~lu;
        up_word   = {$urandom, $urandom};
        down_word = {$urandom, $urandom};
    endtask

    task automatic rand_case(input int unsigned lim, input string tag);
        int unsigned ua [K];
        int unsigned da [K];
        for (int i = 0; i < K; i++) begin
            ua[i] = $urandom_range(lim, 0);
            da[i] = $urandom_range(lim, 0);
        end
        sort_keys(ua, 1'b0);
        sort_keys(da, 1'b1);
        issue(ua, da, 1'($urandom), 1'($urandom), tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            up_word   = {$urandom, $urandom};
            down_word = {$urandom, $urandom};
            hi_up     = 1'($urandom);
            lo_up     = 1'($urandom);
            @(posedge clk); #1;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "out_valid with nothing accepted", W'(1), W'(0));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc == e.cyc, "R1", {"latency ", e.tag}, W'(cyc), W'(e.cyc));
                check(hi_word == e.hi, "R3/R5", {"hi_word ", e.tag}, hi_word, e.hi);
                check(lo_word == e.lo, "R4/R5", {"lo_word ", e.tag}, lo_word, e.lo);
            end
        end
    end

    initial begin
        int unsigned ua [K];
        int unsigned da [K];
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8", "out_valid in reset", W'(out_valid), W'(0));
        check(hi_word == '0, "R8", "hi_word in reset", hi_word, W'(0));
        check(lo_word == '0, "R8", "lo_word in reset", lo_word, W'(0));
        @(posedge clk); #1;
        rst = 1'b0;

        // R2: idle traffic with garbage must give nothing
        idle(LAT + 3);
        check(out_valid == 1'b0, "R2", "idle out_valid", W'(out_valid), W'(0));

        // R4: all keys equal
        for (int i = 0; i < K; i++) begin ua[i] = 77; da[i] = 77; end
        issue(ua, da, 1'b1, 1'b0, "R4_all_equal");

        // R7: zero against all-ones fields, both ways round
        for (int i = 0; i < K; i++) begin ua[i] = 0; da[i] = FMAX; end
        issue(ua, da, 1'b1, 1'b1, "R7_zero_vs_max");
        for (int i = 0; i < K; i++) begin ua[i] = FMAX; da[i] = 0; end
        issue(ua, da, 1'b0, 1'b0, "R7_max_vs_zero");
        for (int i = 0; i < K; i++) begin ua[i] = (i < K/2) ? 0 : FMAX; da[i] = (i < K/2) ? FMAX : 0; end
        issue(ua, da, 1'b0, 1'b1, "R7_mixed_extremes");

        // R3: one operand entirely above the other
        for (int i = 0; i < K; i++) begin ua[i] = 200 + i; da[i] = K - i; end
        issue(ua, da, 1'b1, 1'b0, "R3_up_dominates");
        for (int i = 0; i < K; i++) begin ua[i] = i; da[i] = 250 - i; end
        issue(ua, da, 1'b0, 1'b1, "R3_down_dominates");

        // R6: back-to-back pairs with every direction combination
        for (int d = 0; d < 4; d++) rand_case(FMAX, "R6_dir_sweep");
        for (int i = 0; i < K; i++) begin ua[i] = 10*i; da[i] = 10*(K-i) + 5; end
        issue(ua, da, 1'b0, 1'b0, "R5_down_down");
        issue(ua, da, 1'b1, 1'b1, "R5_up_up");
        issue(ua, da, 1'b1, 1'b0, "R5_up_down");
        issue(ua, da, 1'b0, 1'b1, "R5_down_up");

        idle(LAT + 2);
        check(exp_q.size() == 0, "R1", "results pending after drain", W'(exp_q.size()), W'(0));

        // R4: heavy duplicates from a tiny alphabet
        for (int n = 0; n < 60; n++) begin
            rand_case(3, "R4_dups");
            if ($urandom_range(3, 0) == 0) idle($urandom_range(3, 1));
        end

        // R3/R5: full-range random, mixed streaming and gaps
        for (int n = 0; n < 300; n++) begin
            rand_case(FMAX, "R3_random");
            if ($urandom_range(4, 0) == 0) idle($urandom_range(2, 1));
        end

        idle(LAT + 3);
        check(exp_q.size() == 0, "R1", "results pending at end", W'(exp_q.size()), W'(0));
        check(out_valid == 1'b0, "R2", "out_valid after drain", W'(out_valid), W'(0));
        done = 1'b1;
        finish_run();
    end

endmodule